// File: doc/BRIEF.md
# Token-ring cascadable FIFO slice

This block is a first-in first-out buffer slice that can be chained with identical slices into one deeper FIFO. Each slice owns its storage, its write and read pointers, an occupancy count and local empty and full flags. The right to accept a write and the right to accept a read each live in exactly one slice at a time. When a slice stores into, or reads from, its last storage location, it hands that right to the next slice in the ring with a one-clock pulse on its expansion output. The slice marked by a low first-load input holds both rights when reset ends.

A slice whose two-line expansion input is held low for the whole reset keeps both rights for good and acts as a plain FIFO of one slice's depth. The wrapper builds a ring of `SLICES` slices, or a single standalone slice when `SOLO` is set. It forms the composite flags by OR-ing the active-low slice flags, so the composite flag is asserted only when every slice asserts its own.

Top module: `fifo_chain`

## Requirements
- R1: In the first cycle after synchronous reset, `empty_n` is 0, `full_n` is 1 and `rd_valid` is 0, whichever slice is first.
- R2: Words leave in the order they were accepted. A read accepted at a clock edge raises `rd_valid` with the word on `rd_data` for the following cycle only.
- R3: A write presented while `full_n` is 0 is dropped. The word never appears at the output, and `full_n` stays 0 unless a read is also accepted.
- R4: A read presented while `empty_n` is 0 is dropped. `rd_valid` stays 0 in the next cycle.
- R5: `empty_n` is 0 exactly when the total stored count is zero. `full_n` is 0 exactly when the count equals `SLICES*DEPTH`.
- R6: After reset, only the slice with first-load low holds the write right and the read right. At every later cycle, exactly one slice holds each right.
- R7: With `DEPTH` of 2 or more, an accepted write (read) at a slice's last location drives that slice's write-pass (read-pass) line low for one clock. The next slice in the ring holds the right during that pulse cycle.
- R8: A slice whose expansion input is 2'b00 throughout reset keeps both rights and never pulses. Alone it fills after `DEPTH` writes and returns them in order.
- R9: A write and a read presented in the same cycle, with neither flag asserted, are both accepted, and the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Word read, valid with `rd_valid` |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |

## Verification
Flag effects show up right after the edge that accepts an operation, and read data follows one cycle after its accepting edge. The bench therefore drives and samples on the falling edge. At each falling edge it compares the flags with a model count that includes every operation accepted up to the previous rising edge. It expects `rd_valid` exactly when the model accepted a read one cycle earlier. A scoreboard queue checks the data order across slice boundaries, after wrap-around, through dropped writes on a full ring and through simultaneous reads and writes. A second, standalone instance is checked the same way for fill depth and order.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    // Two active-low pass lines between neighbouring slices.
    typedef struct packed {
        logic wr_n;
        logic rd_n;
    } xlink_t;

    localparam xlink_t XLINK_SOLO = '{wr_n: 1'b0, rd_n: 1'b0};

    // Both lines held low means no neighbour is attached.
    function automatic logic is_solo(input xlink_t x);
        return !x.wr_n && !x.rd_n;
    endfunction

endpackage

// File: rtl/chain_ram.sv
module chain_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/chain_right.sv
// One circulating right (write or read): held bit plus outgoing pass pulse.
module chain_right (
    input  logic clk,
    input  logic rst,
    input  logic first_n,
    input  logic solo,
    input  logic pass_in,
    input  logic advance,
    output logic own,
    output logic pass_out_n
);
    logic held_q;
    logic pulse_q;

    // The right is usable already during the incoming pulse cycle.
    assign own        = solo | held_q | pass_in;
    assign pass_out_n = ~pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= ~first_n;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= advance & ~solo;
            if (advance & ~solo)
                held_q <= 1'b0;
            else if (pass_in)
                held_q <= 1'b1;
        end
    end
endmodule

// File: rtl/chain_slice.sv
module chain_slice
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_n,
    input  xlink_t           xin,
    output xlink_t           xout,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty_n,
    output logic             full_n,
    output logic             wr_own,
    output logic             rd_own
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic             solo_q;
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             wr_go, rd_go;
    logic [WIDTH-1:0] ram_q;
    logic             wpass_n, rpass_n;

    // Mode is sampled while reset is held; neighbours idle high then.
    always_ff @(posedge clk) begin
        if (rst) solo_q <= is_solo(xin);
    end

    assign wr_go = wr_en & wr_own & (count != FULLC);
    assign rd_go = rd_en & rd_own & (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_go) begin
                rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
                rd_data <= ram_q;
            end
            case ({wr_go, rd_go})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    chain_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (ram_q)
    );

    chain_right u_wr_right (
        .clk        (clk),
        .rst        (rst),
        .first_n    (first_n),
        .solo       (solo_q),
        .pass_in    (~xin.wr_n),
        .advance    (wr_go && (wptr == LAST)),
        .own        (wr_own),
        .pass_out_n (wpass_n)
    );

    chain_right u_rd_right (
        .clk        (clk),
        .rst        (rst),
        .first_n    (first_n),
        .solo       (solo_q),
        .pass_in    (~xin.rd_n),
        .advance    (rd_go && (rptr == LAST)),
        .own        (rd_own),
        .pass_out_n (rpass_n)
    );

    assign xout    = '{wr_n: wpass_n, rd_n: rpass_n};
    assign empty_n = (count != '0);
    assign full_n  = (count != FULLC);
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH  = 9,
    parameter int DEPTH  = 4,
    parameter int SLICES = 3,
    parameter bit SOLO   = 1'b0,
    localparam int NS    = SOLO ? 1 : SLICES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty_n,
    output logic             full_n
);
    logic [NS-1:0]    wpass_n, rpass_n, wr_own, rd_own;
    logic [NS-1:0]    s_empty_n, s_full_n, s_valid;
    logic [WIDTH-1:0] s_data [NS];

    for (genvar i = 0; i < NS; i++) begin : g_slice
        xlink_t link_in, link_out;

        if (SOLO) begin : g_solo
            assign link_in = XLINK_SOLO;
        end else begin : g_ring
            assign link_in = '{wr_n: wpass_n[(i + NS - 1) % NS],
                               rd_n: rpass_n[(i + NS - 1) % NS]};
        end

        chain_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .first_n  (i != 0),
            .xin      (link_in),
            .xout     (link_out),
            .wr_en    (wr_en),
            .wr_data  (wr_data),
            .rd_en    (rd_en),
            .rd_data  (s_data[i]),
            .rd_valid (s_valid[i]),
            .empty_n  (s_empty_n[i]),
            .full_n   (s_full_n[i]),
            .wr_own   (wr_own[i]),
            .rd_own   (rd_own[i])
        );

        assign wpass_n[i] = link_out.wr_n;
        assign rpass_n[i] = link_out.rd_n;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NS; i++) begin
            if (s_valid[i]) rd_data = rd_data | s_data[i];
        end
    end

    assign rd_valid = |s_valid;
    assign empty_n  = |s_empty_n;
    assign full_n   = |s_full_n;
endmodule

// File: rtl/fifo_chain_checker.sv
module fifo_chain_checker #(
    parameter int NS = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          empty_n,
    input logic          full_n,
    input logic [NS-1:0] wr_own,
    input logic [NS-1:0] rd_own,
    input logic [NS-1:0] wpass_n,
    input logic [NS-1:0] rpass_n
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!empty_n && full_n && !rd_valid));

    p_valid_follows_read_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rd_en) && $past(empty_n)));

    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en) |=> !full_n);

    p_empty_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en) |=> (!empty_n && !rd_valid));

    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n));

    p_one_writer_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot(wr_own));

    p_one_reader_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot(rd_own));

    for (genvar i = 0; i < NS; i++) begin : g_pass
        p_wpass_single_r7: assert property (@(posedge clk) disable iff (rst)
            !wpass_n[i] |=> wpass_n[i]);
        p_rpass_single_r7: assert property (@(posedge clk) disable iff (rst)
            !rpass_n[i] |=> rpass_n[i]);
        p_wpass_hands_r7: assert property (@(posedge clk) disable iff (rst)
            !wpass_n[i] |-> wr_own[(i + 1) % NS]);
        p_rpass_hands_r7: assert property (@(posedge clk) disable iff (rst)
            !rpass_n[i] |-> rd_own[(i + 1) % NS]);
    end
endmodule

bind fifo_chain fifo_chain_checker #(.NS(NS)) u_fifo_chain_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .wr_own   (wr_own),
    .rd_own   (rd_own),
    .wpass_n  (wpass_n),
    .rpass_n  (rpass_n)
);

// File: tb/fifo_chain_bench.sv
`timescale 1ns/1ps
module fifo_chain_bench;
    localparam int W   = 9;
    localparam int D   = 4;
    localparam int S   = 3;
    localparam int CAP = S * D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rd_valid, empty_n, full_n;

    logic         wr_en_s = 1'b0, rd_en_s = 1'b0;
    logic [W-1:0] wr_data_s = '0;
    logic [W-1:0] rd_data_s;
    logic         rd_valid_s, empty_n_s, full_n_s;

    fifo_chain #(.WIDTH(W), .DEPTH(D), .SLICES(S)) u_fifo_chain (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n)
    );

    fifo_chain #(.WIDTH(W), .DEPTH(D), .SLICES(S), .SOLO(1'b1)) u_fifo_chain_solo (
        .clk(clk), .rst(rst), .wr_en(wr_en_s), .wr_data(wr_data_s), .rd_en(rd_en_s),
        .rd_data(rd_data_s), .rd_valid(rd_valid_s), .empty_n(empty_n_s), .full_n(full_n_s)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_q [$];
    int occ      = 0;
    bit prev_acc = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: checks last cycle's results at the falling edge, then drives.
    task automatic step(input bit we, input logic [W-1:0] d, input bit re);
        bit wacc, racc;
        @(negedge clk);
        if (prev_acc) chk(rd_valid == 1'b1, "R2 valid after read", rd_valid, 1);
        else          chk(rd_valid == 1'b0, "R4 no valid without read", rd_valid, 0);
        chk(empty_n == (occ != 0),   "R5 empty_n", empty_n, occ != 0);
        chk(full_n  == (occ != CAP), "R5 full_n",  full_n,  occ != CAP);
        wacc = we && (occ != CAP);   // R3: write on full dropped
        racc = re && (occ != 0);     // R4: read on empty dropped
        if (wacc) exp_q.push_back(d);
        occ      = occ + int'(wacc) - int'(racc);
        prev_acc = racc;
        wr_en    = we;
        wr_data  = d;
        rd_en    = re;
    endtask

    // Monitor: scoreboard compare of the ring output (R2, R6, R7 order across slices).
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected word", int'(rd_data), -1);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R2,R6,R7 order", int'(rd_data), int'(e));
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [W-1:0] seq;
        seq = 9'd1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state on both instances (first post-reset cycle)
        @(negedge clk);
        chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        chk(full_n  == 1'b1, "R1 full_n", full_n, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(empty_n_s == 1'b0 && full_n_s == 1'b1, "R1 solo flags", {empty_n_s, full_n_s}, 1);

        step(1'b0, '0, 1'b1);                       // R4 read on empty
        for (int k = 0; k < 14; k++) begin          // fill past capacity, R3
            step(1'b1, seq, 1'b0);
            seq = seq + 9'd7;
        end
        step(1'b1, 9'h1FF, 1'b0);                   // R3 marker must never appear
        step(1'b0, '0, 1'b0);
        chk(full_n == 1'b0, "R3 full stays after dropped write", full_n, 0);
        for (int k = 0; k < 5; k++) begin           // read+write while full
            step(1'b1, seq, 1'b1);
            seq = seq + 9'd7;
        end
        for (int k = 0; k < 12; k++) step(1'b0, '0, 1'b1);
        // R9 simultaneous accept with one word stored
        step(1'b1, seq, 1'b0); seq = seq + 9'd3;
        step(1'b1, seq, 1'b1); seq = seq + 9'd3;
        step(1'b0, '0, 1'b0);
        chk(occ == 1 && empty_n && full_n, "R9 count unchanged", occ, 1);
        for (int i = 0; i < 150; i++) begin         // mixed pattern, wraps the ring
            step((i % 5) != 1, seq, (i % 3) != 0);
            seq = seq + 9'd5;
        end
        for (int i = 0; i < 40; i++) begin          // burst writes, then mixed
            step(1'b1, seq, (i % 4) == 0);
            seq = seq + 9'd11;
        end
        for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);                       // R4 read on empty again
        step(1'b0, '0, 1'b0);
        chk(exp_q.size() == 0, "R2 all words returned", exp_q.size(), 0);

        // R8 standalone instance: depth of one slice, in order
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            wr_en_s   = 1'b1;
            wr_data_s = W'(9'h100 + k);
        end
        @(negedge clk);
        wr_en_s = 1'b0;
        chk(full_n_s == 1'b0 && empty_n_s == 1'b1, "R8 full after DEPTH writes",
            {full_n_s, empty_n_s}, 1);
        rd_en_s = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rd_valid_s == 1'b1, "R8 read valid", rd_valid_s, 1);
            chk(rd_data_s == W'(9'h100 + k), "R8 order", int'(rd_data_s), 9'h100 + k);
            if (k == 3) rd_en_s = 1'b0;
        end
        @(negedge clk);
        chk(empty_n_s == 1'b0 && rd_valid_s == 1'b0, "R8 empty after DEPTH reads",
            {empty_n_s, rd_valid_s}, 0);
        rd_en_s = 1'b1;
        @(negedge clk);
        rd_en_s = 1'b0;
        chk(rd_valid_s == 1'b0, "R4 solo read on empty", rd_valid_s, 0);
        summary();
    end
endmodule